// File: doc/BRIEF.md
# Shared-Bus Word Memory with Enable-Overlap Writes

This block is a 2048-word by 8-bit memory whose control follows an asynchronous static-memory pin protocol, rebuilt for a clocked fabric. Three active-low controls steer it: a select (`ce_n`), a write strobe (`we_n`) and a drive gate (`oe_n`). Every pin is registered on a fast clock before use. The shared data bus is split into a data-in path, a data-out path and a drive-enable flag. An outer wrapper would join these into a tri-state pad.

A write spans the interval in which select and write strobe are both sampled low. Either control may close that interval by rising first. The word is committed on the first clock sample that shows the interval closed. It uses the address and data captured in that same sample, so the host keeps both steady until the closing control has been sampled high. A read is any sample with select low and write strobe high. The addressed word comes out after a parameterised number of clock cycles, and `bus_valid` marks when the output has settled.

Top module: `sram_overlap_top`

## Requirements
- R1: The address is 11 bits (locations 0 to 2047) and words are 8 bits. A word written at any location, including 0 and 2047, reads back unchanged with the same bit polarity.
- R2: With `ce_n`=0, `we_n`=1 and `oe_n`=0 held steady, `bus_oe` is 1 two clock edges after the pins are applied. `bus_valid` is 0 after RD_LAT+1 edges and 1 after RD_LAT+2 edges (RD_LAT defaults to 2), and `dout` then holds the addressed word.
- R3: Two edges after any sample with `ce_n`=1, `oe_n`=1 or `we_n`=0, `bus_oe` is 0.
- R4: No word changes unless `ce_n` and `we_n` are sampled low together. Write-strobe-low with select high, and select-low with write strobe high, leave memory untouched.
- R5: A write whose overlap is closed by `we_n` rising while `ce_n` stays low commits the word. A read of the same address that starts at once returns the new word when `bus_valid` rises.
- R6: A write whose overlap is closed by `ce_n` rising first commits the word.
- R7: The committed address and data are those sampled at the first clock edge at which the overlap is found closed. Earlier addresses and data presented during the overlap are not written.
- R8: If `we_n` falls before `ce_n`, and `ce_n` rises before `we_n`, then `bus_oe` stays 0 for the whole cycle, even with `oe_n` held low.
- R9: After synchronous reset, `bus_oe` and `bus_valid` are 0.
- R10: When the address changes during a settled read, `bus_valid` is 0 one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output drive gate |
| addr | input | 11 | Word address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data toward the bus |
| bus_oe | output | 1 | Bus drive enable for the pad |
| bus_valid | output | 1 | Read data has settled for the current address |

## Verification
Writes are closed by the write strobe alone and by the select alone. This separates the two termination paths and shows that both commit. A write closed by the strobe is followed at once by a read of the same word, which exposes any stale read-port data in the cycle after commit. The address and data are changed partway through an overlap, which tells a commit at the closing sample apart from one at the opening sample. Strobe-only and select-only patterns are also applied, together with a write where the strobe wraps the select, to show that no write happens without a true overlap and that the drive stays off throughout.

// File: rtl/sram_ovl_pkg.sv
package sram_ovl_pkg;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

  // select and write strobe both low
  function automatic logic in_overlap(input ctl_t c);
    return !c.ce_n && !c.we_n;
  endfunction

  // bus may be driven only when selected, gated open and not writing
  function automatic logic may_drive(input ctl_t c);
    return !c.ce_n && !c.oe_n && c.we_n;
  endfunction

endpackage

// File: rtl/sovl_pin_sampler.sv
module sovl_pin_sampler
  import sram_ovl_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output ctl_t          s_ctl,
  output ctl_t          p_ctl,
  output logic [AW-1:0] s_addr,
  output logic [AW-1:0] p_addr,
  output logic [DW-1:0] s_din
);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ctl  <= CTL_IDLE;
      p_ctl  <= CTL_IDLE;
      s_addr <= '0;
      p_addr <= '0;
      s_din  <= '0;
    end else begin
      s_ctl  <= '{ce_n: ce_n, we_n: we_n, oe_n: oe_n};
      p_ctl  <= s_ctl;
      s_addr <= addr;
      p_addr <= s_addr;
      s_din  <= din;
    end
  end

endmodule

// File: rtl/sovl_write_ctrl.sv
module sovl_write_ctrl
  import sram_ovl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_t s_ctl,
  output logic wr_en
);

  logic ovl_q;

  always_ff @(posedge clk) begin
    if (rst) ovl_q <= 1'b0;
    else     ovl_q <= in_overlap(s_ctl);
  end

  // commit on the first sample that finds the overlap closed
  assign wr_en = ovl_q && !in_overlap(s_ctl);

  // R5: a commit cannot repeat without a fresh overlap
  assert_commit_single_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

endmodule

// File: rtl/sovl_ram.sv
module sovl_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sovl_rd_pipe.sv
module sovl_rd_pipe #(
  parameter int DW     = 8,
  parameter int STAGES = 1
) (
  input  logic          clk,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_regs
      logic [DW-1:0] st [STAGES];
      always_ff @(posedge clk) begin
        st[0] <= d;
        for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
      assign q = st[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/sram_overlap_top.sv
module sram_overlap_top
  import sram_ovl_pkg::*;
#(
  parameter int AW     = 11,
  parameter int DW     = 8,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          bus_oe,
  output logic          bus_valid
);

  localparam int CW = $clog2(RD_LAT + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(RD_LAT);

  ctl_t          s_ctl, p_ctl;
  logic [AW-1:0] s_addr, p_addr;
  logic [DW-1:0] s_din, ram_q;
  logic          wr_en, chg, drive_q;
  logic [CW-1:0] settle_cnt;

  sovl_pin_sampler #(.AW(AW), .DW(DW)) u_smp (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .s_ctl(s_ctl), .p_ctl(p_ctl),
    .s_addr(s_addr), .p_addr(p_addr), .s_din(s_din)
  );

  sovl_write_ctrl u_wctl (
    .clk(clk), .rst(rst), .s_ctl(s_ctl), .wr_en(wr_en)
  );

  sovl_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(s_addr), .wdata(s_din),
    .raddr(s_addr), .rdata(ram_q)
  );

  sovl_rd_pipe #(.DW(DW), .STAGES(RD_LAT - 1)) u_pipe (
    .clk(clk), .d(ram_q), .q(dout)
  );

  // read operands moved since the previous sample
  assign chg = (s_ctl != p_ctl) || (s_addr != p_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      settle_cnt <= '0;
      drive_q    <= 1'b0;
    end else begin
      drive_q <= may_drive(s_ctl);
      if (chg)                     settle_cnt <= '0;
      else if (settle_cnt != CNT_FULL) settle_cnt <= settle_cnt + 1'b1;
    end
  end

  assign bus_oe    = drive_q;
  assign bus_valid = drive_q && !chg && (settle_cnt == CNT_FULL);

  // R3: any blocking control at the pins turns the drive off two edges later
  assert_drive_blocked_R3: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n || !we_n) |=> ##1 !bus_oe);

  // R2: settled data is only flagged while the bus is driven
  assert_valid_needs_drive_R2: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> bus_oe);

  // R4: a commit needs select and strobe low together at the pins
  assert_write_needs_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(!ce_n && !we_n, 2));

  // R10: an address move at the pins drops the valid flag next edge
  assert_valid_drops_R10: assert property (@(posedge clk) disable iff (rst)
    (addr != $past(addr)) |=> !bus_valid);

endmodule

// File: tb/test_sram_overlap_top.sv
`timescale 1ns/1ps
module test_sram_overlap_top;

  localparam int AW = 11;
  localparam int DW = 8;
  localparam int RD_LAT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic bus_oe, bus_valid;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sram_overlap_top #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT)) i_sram_overlap_top (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .bus_oe(bus_oe), .bus_valid(bus_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (n) @(posedge clk);
  endtask

  // write with the chosen enable rising first; addr/din held until both are high
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ce_first);
    @(negedge clk);
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(posedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
    @(negedge clk);
    addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    repeat (RD_LAT + 2) @(posedge clk);
    @(negedge clk);
    d = dout; v = bus_valid;
  endtask

  task automatic t_reset_R9();
    @(negedge clk);
    chk(bus_oe == 1'b0, "R9 bus_oe after reset", bus_oe, 0);
    chk(bus_valid == 1'b0, "R9 bus_valid after reset", bus_valid, 0);
  endtask

  task automatic t_walk_R1();
    logic [DW-1:0] d; logic v;
    wr(11'd0, 8'hA5, 1'b0);
    wr(11'd2047, 8'h3C, 1'b0);
    wr(11'd1024, 8'h80, 1'b1);
    wr(11'd1, 8'h01, 1'b1);
    rd(11'd0, d, v);    chk(v && d == 8'hA5, "R1 addr 0", d, 8'hA5);
    rd(11'd2047, d, v); chk(v && d == 8'h3C, "R1 addr 2047", d, 8'h3C);
    rd(11'd1024, d, v); chk(v && d == 8'h80, "R1 addr 1024", d, 8'h80);
    rd(11'd1, d, v);    chk(v && d == 8'h01, "R1 addr 1", d, 8'h01);
    idle(3);
  endtask

  task automatic t_latency_R2_R10();
    wr(11'd500, 8'h77, 1'b0);
    idle(3);
    @(negedge clk);
    addr = 11'd500; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(bus_oe == 1'b1, "R2 bus_oe after 2 edges", bus_oe, 1);
    repeat (RD_LAT - 1) @(posedge clk);
    @(negedge clk);
    chk(bus_valid == 1'b0, "R2 valid low after RD_LAT+1 edges", bus_valid, 0);
    @(posedge clk);
    @(negedge clk);
    chk(bus_valid == 1'b1, "R2 valid high after RD_LAT+2 edges", bus_valid, 1);
    chk(dout == 8'h77, "R2 read data", dout, 8'h77);
    addr = 11'd501;
    @(posedge clk);
    @(negedge clk);
    chk(bus_valid == 1'b0, "R10 valid drop after address move", bus_valid, 0);
    idle(3);
  endtask

  task automatic t_block_R3();
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    chk(bus_oe == 1'b0, "R3 select high", bus_oe, 0);
    ce_n = 1'b0; oe_n = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    chk(bus_oe == 1'b0, "R3 gate high", bus_oe, 0);
    oe_n = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    chk(bus_oe == 1'b1, "R3 open again", bus_oe, 1);
    we_n = 1'b0; din = 8'h00; addr = 11'd900;
    repeat (2) @(posedge clk); @(negedge clk);
    chk(bus_oe == 1'b0, "R3 strobe low", bus_oe, 0);
    @(negedge clk);
    ce_n = 1'b1;
    @(posedge clk);
    idle(3);
  endtask

  task automatic t_no_overlap_R4();
    logic [DW-1:0] d; logic v;
    wr(11'd100, 8'h5A, 1'b0);
    @(negedge clk);
    addr = 11'd100; din = 8'hFF; ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b0;
    repeat (3) @(posedge clk);
    idle(2);
    rd(11'd100, d, v);
    chk(v && d == 8'h5A, "R4 no write without overlap", d, 8'h5A);
    idle(3);
  endtask

  task automatic t_we_end_R5();
    @(negedge clk);
    addr = 11'd777; din = 8'hC3; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    we_n = 1'b1;
    repeat (RD_LAT + 2) @(posedge clk);
    @(negedge clk);
    chk(bus_valid == 1'b1, "R5 valid on read after strobe end", bus_valid, 1);
    chk(dout == 8'hC3, "R5 new word read at once", dout, 8'hC3);
    idle(3);
  endtask

  task automatic t_ce_end_R6();
    logic [DW-1:0] d; logic v;
    wr(11'd1500, 8'h96, 1'b1);
    rd(11'd1500, d, v);
    chk(v && d == 8'h96, "R6 commit on select end", d, 8'h96);
    idle(3);
  endtask

  task automatic t_last_sample_R7();
    logic [DW-1:0] d; logic v;
    wr(11'd300, 8'h11, 1'b0);
    wr(11'd301, 8'h22, 1'b0);
    @(negedge clk);
    addr = 11'd300; din = 8'hAA; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    addr = 11'd301; din = 8'hBB;
    repeat (2) @(posedge clk);
    @(negedge clk);
    we_n = 1'b1;
    @(posedge clk);
    idle(2);
    rd(11'd300, d, v); chk(v && d == 8'h11, "R7 early address untouched", d, 8'h11);
    rd(11'd301, d, v); chk(v && d == 8'hBB, "R7 closing address and data", d, 8'hBB);
    idle(3);
  endtask

  task automatic t_wrap_R8();
    logic [DW-1:0] d; logic v;
    int highs = 0;
    @(negedge clk);
    addr = 11'd42; din = 8'h6E; oe_n = 1'b0; ce_n = 1'b1; we_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); we_n = 1'b0;
    for (int i = 0; i < 9; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (bus_oe) highs++;
      if (i == 1) ce_n = 1'b0;
      if (i == 4) ce_n = 1'b1;
      if (i == 5) we_n = 1'b1;
    end
    chk(highs == 0, "R8 drive off through wrapped write", highs, 0);
    rd(11'd42, d, v);
    chk(v && d == 8'h6E, "R8 wrapped write committed", d, 8'h6E);
    idle(3);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_R9();
    t_walk_R1();
    t_latency_R2_R10();
    t_block_R3();
    t_no_overlap_R4();
    t_we_end_R5();
    t_ce_end_R6();
    t_last_sample_R7();
    t_wrap_R8();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule